// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps an 8-bit status word that tells software which reset source caused the most recent reset. It has four single-cycle event strobes: power-on, external pin, brown-out and watchdog. Each strobe sets its own flag. The flags are sticky. A flag drops only when software writes a zero to its bit, or, for the three secondary flags, when a power-on event occurs.

The block does not generate the reset sources, filter the reset pin or stretch the reset pulse. It only captures the events and clears the flags. Its storage has no reset input. The power-on strobe is its only initialiser, so a flag survives the very reset it records.

The usual software sequence is:
1. Read `reg_rdata` early after boot.
2. Write zeros to the bits it has handled.
3. At the next boot, inspect whatever has accumulated since.

Top module: `rcause_status_reg`

## Requirements
- R1: Bits 7..4 of `reg_rdata` always read zero, and writes to those bits have no effect.
- R2: The flag positions are bit 3 watchdog, bit 2 brown-out, bit 1 external and bit 0 power-on. A strobe on a source sets its bit, and the bit is visible on `reg_rdata` in the cycle after the strobe.
- R3: A set flag stays set through later idle cycles, through non-power-on events from other sources, and through writes of one to its bit.
- R4: A write with `reg_we` high clears every flag whose bit in `reg_wdata` is zero and leaves flags whose bit is one unchanged. The result shows in the cycle after the write.
- R5: A power-on strobe makes `reg_rdata[3:0]` equal 4'b0001 in the next cycle. This holds even if other strobes or a write fall in the same cycle.
- R6: The power-on flag is cleared only by a write of zero to bit 0. External, brown-out and watchdog events leave it unchanged.
- R7: When a source strobe and a write that would clear the same flag fall in the same cycle, the flag ends up set.
- R8: Flags of different sources are independent, so several may be set together when software has not cleared them in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on event strobe, also the only storage initialiser |
| ext_pulse | input | 1 | External pin reset event strobe |
| bor_pulse | input | 1 | Brown-out reset event strobe |
| wdt_pulse | input | 1 | Watchdog reset event strobe |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Write data; a zero in a flag bit clears that flag |
| reg_rdata | output | 8 | Current register contents |

## Verification
The two functions that can land in the same cycle are a software write that clears a flag and a strobe that sets that same flag. A power-on strobe can also coincide with secondary strobes and with writes. The bench drives these overlaps in a single cycle, including an all-zero write combined with a watchdog strobe. It then compares the next-cycle read value against its own model, where set beats write-clear and power-on beats everything. The relevant assertions in each flag cell and in the top check the same priority on every cycle.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 4;

  // bit positions; software decodes these
  localparam int POS_POR = 0;
  localparam int POS_EXT = 1;
  localparam int POS_BOR = 2;
  localparam int POS_WDT = 3;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [REG_W-1:0]   word_t;

  // power-on clear dominates, then set, then software clear
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr_clr, input logic por_clr);
    logic n;
    if (por_clr)     n = 1'b0;
    else if (set)    n = 1'b1;
    else if (wr_clr) n = 1'b0;
    else             n = cur;
    return n;
  endfunction

  // bits written as zero request a clear
  function automatic src_vec_t zero_clear_mask(input logic we, input src_vec_t wd);
    return we ? ~wd : '0;
  endfunction

  function automatic word_t pack_word(input src_vec_t flags);
    word_t w;
    w = '0;
    w[NUM_SRC-1:0] = flags;
    return w;
  endfunction
endpackage

// File: rtl/rcause_wr_decode.sv
module rcause_wr_decode
  import rcause_pkg::*;
(
  input  logic     we_i,
  input  src_vec_t wdata_i,
  output src_vec_t clr_o
);
  assign clr_o = zero_clear_mask(we_i, wdata_i);
endmodule

// File: rtl/rcause_flag.sv
module rcause_flag
  import rcause_pkg::*;
(
  input  logic clk,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic clr_por_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk)
    q <= flag_next(q, set_i, clr_wr_i, clr_por_i);

  assign q_o = q;

  // R2 R7
  set_wins_chk: assert property (@(posedge clk) disable iff (clr_por_i)
    set_i |=> q_o);

  // R4
  wr_clear_chk: assert property (@(posedge clk) disable iff (clr_por_i)
    (clr_wr_i && !set_i) |=> !q_o);

  // R3
  sticky_hold_chk: assert property (@(posedge clk)
    (!set_i && !clr_wr_i && !clr_por_i) |=> $stable(q_o));
endmodule

// File: rtl/rcause_rd_pack.sv
module rcause_rd_pack
  import rcause_pkg::*;
(
  input  src_vec_t flags_i,
  output word_t    rdata_o
);
  assign rdata_o = pack_word(flags_i);
endmodule

// File: rtl/rcause_status_reg.sv
module rcause_status_reg
  import rcause_pkg::*;
(
  input  logic             clk,
  input  logic             por_pulse,
  input  logic             ext_pulse,
  input  logic             bor_pulse,
  input  logic             wdt_pulse,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  src_vec_t evt_vec;
  src_vec_t wr_clr;
  src_vec_t por_clr;
  src_vec_t flags;
  logic     rsvd_wr_seen;

  always_comb begin
    evt_vec          = '0;
    evt_vec[POS_POR] = por_pulse;
    evt_vec[POS_EXT] = ext_pulse;
    evt_vec[POS_BOR] = bor_pulse;
    evt_vec[POS_WDT] = wdt_pulse;
  end

  assign rsvd_wr_seen = reg_we && (|reg_wdata[REG_W-1:NUM_SRC]);

  rcause_wr_decode u_dec (
    .we_i    (reg_we),
    .wdata_i (reg_wdata[NUM_SRC-1:0]),
    .clr_o   (wr_clr)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_flag
      if (gi == POS_POR) begin : g_por
        assign por_clr[gi] = 1'b0;
      end else begin : g_sec
        assign por_clr[gi] = por_pulse;
      end
      rcause_flag u_flag (
        .clk       (clk),
        .set_i     (evt_vec[gi]),
        .clr_wr_i  (wr_clr[gi]),
        .clr_por_i (por_clr[gi]),
        .q_o       (flags[gi])
      );
    end
  endgenerate

  rcause_rd_pack u_pack (
    .flags_i (flags),
    .rdata_o (reg_rdata)
  );

  // R1
  rsvd_zero_chk: assert property (@(posedge clk)
    rsvd_wr_seen |=> (reg_rdata[REG_W-1:NUM_SRC] == '0));

  // R5
  por_pattern_chk: assert property (@(posedge clk)
    por_pulse |=> (reg_rdata[NUM_SRC-1:0] == src_vec_t'(1)));

  // R6
  por_keep_chk: assert property (@(posedge clk) disable iff (por_pulse)
    !(reg_we && !reg_wdata[POS_POR]) |=> $stable(reg_rdata[POS_POR]));
endmodule

// File: tb/rcause_status_reg_test.sv
module rcause_status_reg_test;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic por = 0, ext = 0, bor = 0, wdt = 0, we = 0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  logic [3:0] model = 4'h0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  rcause_status_reg uut (
    .clk(clk), .por_pulse(por), .ext_pulse(ext), .bor_pulse(bor),
    .wdt_pulse(wdt), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd)
  );

  // driver: one cycle of stimulus plus its expected result
  task automatic step(input logic p, input logic e, input logic b, input logic w,
                      input logic wen, input logic [7:0] data, input string tag);
    item_t it;
    logic [3:0] evt;
    @(negedge clk);
    por = p; ext = e; bor = b; wdt = w; we = wen; wd = data;
    evt = {w, b, e, 1'b0};
    if (p) model = 4'b0001;
    else begin
      for (int i = 0; i < 4; i++) begin
        if (evt[i]) model[i] = 1'b1;
        else if (wen && !data[i]) model[i] = 1'b0;
      end
    end
    it.exp = {4'h0, model};
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (rd !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", it.tag, rd, it.exp);
      end
    end
  end

  initial begin
    step(1,0,0,0,0,8'h00,"R5 power-on initial");
    step(0,0,0,0,0,8'h00,"R3 idle hold");
    step(0,1,0,0,0,8'h00,"R2 external set");
    step(0,0,1,0,0,8'h00,"R8 brown-out accumulates");
    step(0,0,0,1,0,8'h00,"R8 watchdog accumulates");
    step(0,0,0,0,1,8'hFF,"R3 write ones keeps");
    step(0,0,0,0,1,8'hFB,"R4 clear brown-out only");
    step(0,1,0,0,0,8'h00,"R6 ext event keeps por flag");
    step(0,0,0,0,1,8'hFE,"R4 clear por flag");
    step(0,0,1,1,0,8'h00,"R6 events do not set por flag");
    step(0,0,0,1,1,8'h00,"R7 set beats clear");
    step(0,0,0,0,1,8'hF0,"R1 reserved write ignored");
    step(0,0,0,0,0,8'h00,"R3 hold after clear");
    step(0,1,1,1,1,8'h00,"R7 all sets beat clear");
    step(1,1,1,1,1,8'h00,"R5 power-on dominates");
    step(0,0,0,0,1,8'h00,"R6 write zero clears por");
    step(0,0,0,0,0,8'h00,"R3 idle empty");
    step(0,1,0,0,0,8'h00,"R2 external bit1");
    step(1,0,0,0,0,8'h00,"R5 power-on clears ext");
    step(0,0,0,0,0,8'h00,"R1 idle");
    @(negedge clk);
    por = 0; ext = 0; bor = 0; wdt = 0; we = 0; wd = 8'h00;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule